// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external serial master read and write the 16-bit registers of a chip through a four-wire serial link. The master selects the block by pulling chip select low. It sends an 8-bit command and then a 16-bit register address, both most significant bit first. A write then carries 16 data bits, which are handed to the core as one write strobe. A read makes the block fetch the register at once. The block then returns a fixed identification word, followed by the register contents. The identification word gives the core a whole word time to supply the data, and it lets the master see that a live slave is answering.

The serial pins are sampled into the core clock domain, and everything runs on that one clock. The serial clock idles low. Input bits are taken on its rising edge, and the output line changes on its falling edge. The output is driven only while read data is being returned. Raising chip select ends any transaction at once. The core side is a simple synchronous port: a read strobe with an address, a read data bus valid a fixed number of cycles later, and a write strobe with an address and data.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset `spi_miso_oe`, `core_rd` and `core_wr` are 0.
- R2: A transaction whose first byte is 0x03 is a read. After the 16 address bits that follow, `core_rd` pulses exactly once, with `core_addr` equal to those bits taken most significant bit first.
- R3: In a read, the first rising serial clock edge after the address finds `spi_miso_oe` at 1 and `spi_miso` carrying the most significant bit of the parameter `CHECK_WORD`. The remaining check bits follow on the next 15 rising edges, most significant first.
- R4: The 16 rising edges after the check word see the register contents returned on `core_rdata`, most significant bit first.
- R5: A transaction whose first byte is 0x02 is a write. After the 16 address bits and the 16th data bit, `core_wr` pulses exactly once, with the address and data taken most significant bit first. `core_rd` does not pulse.
- R6: A write cut short by chip select before its 16th data bit produces no `core_wr`, and the register keeps its old value.
- R7: A command byte other than 0x03 or 0x02 causes no strobe, and `spi_miso_oe` stays 0 until chip select rises.
- R8: A high `spi_cs_n` aborts the transaction and drops `spi_miso_oe`. The next transaction is decoded from its first bit.
- R9: `spi_miso_oe` is 0 during the command and address bits of every transaction and throughout a write.
- R10: `spi_miso` changes only after a falling serial clock edge, and holds steady while the serial clock is high.
- R11: `core_rd` and `core_wr` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad; 0 means high impedance |
| core_addr | output | AW (16) | Register address for the core strobes |
| core_rd | output | 1 | Single-cycle read request |
| core_rdata | input | DW (16) | Read data, valid RD_LATENCY cycles after core_rd |
| core_wr | output | 1 | Single-cycle write request |
| core_wdata | output | DW (16) | Write data qualified by core_wr |

## Verification
The assertions assume three things about the inputs. Each serial clock phase lasts well beyond the synchronizer depth, so the sampled clock never rises and falls in one core cycle. `core_rdata` is valid exactly `RD_LATENCY` cycles after `core_rd`. Chip select stays high for several core cycles between transactions. The stimulus holds each serial clock phase for eight core cycles. It models the register file as a one-cycle synchronous memory and leaves a dozen idle cycles between transactions. Within these bounds, the held-output and enable-drop properties describe the pin behaviour alone and do not depend on the order of edge detection.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

   localparam int CMD_W = 8;
   localparam logic [CMD_W-1:0] CMD_READ  = 8'h03;
   localparam logic [CMD_W-1:0] CMD_WRITE = 8'h02;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_WDATA,
      PH_RDATA,
      PH_IGNORE,
      PH_DONE
   } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic csn_pin,
   input  logic mosi_pin,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_idle,
   output logic mosi_s
);

   localparam logic [2:0] PIN_RST = 3'b010;   // {mosi, cs_n, sclk}

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][2:0] stg;
   logic                   sclk_q;
   logic                   sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg    <= {STAGES{PIN_RST}};
         sclk_q <= 1'b0;
      end else begin
         stg    <= {stg[STAGES-2:0], {mosi_pin, csn_pin, sclk_pin}};
         sclk_q <= sclk_s;
      end
   end

   assign sclk_s    = stg[STAGES-1][0];
   assign cs_idle   = stg[STAGES-1][1];
   assign mosi_s    = stg[STAGES-1][2];
   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_reg_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_idle,
   input  logic          sclk_rise,
   input  logic          mosi_s,
   output logic [AW-1:0] core_addr,
   output logic          core_rd,
   output logic          core_wr,
   output logic [DW-1:0] core_wdata,
   output logic          load_out,
   output logic          out_active
);

   localparam int SHW_AD = (AW > DW) ? AW : DW;
   localparam int SHW    = (SHW_AD > CMD_W) ? SHW_AD : CMD_W;
   localparam int CNT_W  = $clog2(SHW);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DW - 1);

   if (AW < 1 || DW < 2) begin : g_bad_width
      $error("spi_frame_ctrl: AW must be >= 1 and DW >= 2");
   end

   phase_e           phase;
   logic [CNT_W-1:0] bit_cnt;
   logic [SHW-1:0]   shreg;
   logic [SHW-1:0]   sin;
   logic             is_read;

   assign sin        = {shreg[SHW-2:0], mosi_s};
   assign out_active = (phase == PH_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_CMD;
         bit_cnt    <= '0;
         shreg      <= '0;
         is_read    <= 1'b0;
         core_addr  <= '0;
         core_wdata <= '0;
         core_rd    <= 1'b0;
         core_wr    <= 1'b0;
         load_out   <= 1'b0;
      end else if (cs_idle) begin
         phase    <= PH_CMD;
         bit_cnt  <= '0;
         core_rd  <= 1'b0;
         core_wr  <= 1'b0;
         load_out <= 1'b0;
      end else begin
         core_rd  <= 1'b0;
         core_wr  <= 1'b0;
         load_out <= 1'b0;
         if (sclk_rise) begin
            shreg <= sin;
            unique case (phase)
               PH_CMD: begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == CMD_LAST) begin
                     bit_cnt <= '0;
                     if (sin[CMD_W-1:0] == CMD_READ) begin
                        is_read <= 1'b1;
                        phase   <= PH_ADDR;
                     end else if (sin[CMD_W-1:0] == CMD_WRITE) begin
                        is_read <= 1'b0;
                        phase   <= PH_ADDR;
                     end else begin
                        phase   <= PH_IGNORE;
                     end
                  end
               end
               PH_ADDR: begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == ADDR_LAST) begin
                     bit_cnt   <= '0;
                     core_addr <= sin[AW-1:0];
                     if (is_read) begin
                        phase    <= PH_RDATA;
                        core_rd  <= 1'b1;
                        load_out <= 1'b1;
                     end else begin
                        phase    <= PH_WDATA;
                     end
                  end
               end
               PH_WDATA: begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == DATA_LAST) begin
                     bit_cnt    <= '0;
                     core_wdata <= sin[DW-1:0];
                     core_wr    <= 1'b1;
                     phase      <= PH_DONE;
                  end
               end
               default: begin
                  bit_cnt <= bit_cnt;
               end
            endcase
         end
      end
   end

   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd |=> !core_rd);                                        // R11
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |=> !core_wr);                                        // R11
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_rd && core_wr));                                       // R11
   AST_WR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |-> $past(sclk_rise));                                // R5
   AST_RD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd |-> $past(sclk_rise));                                // R2

endmodule

// File: rtl/spi_miso_shifter.sv
module spi_miso_shifter #(
   parameter int            DW         = 16,
   parameter logic [DW-1:0] CHECK_WORD = 16'hC35A,
   parameter int            RD_LATENCY = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_idle,
   input  logic          sclk_fall,
   input  logic          load_out,
   input  logic          out_active,
   input  logic          core_rd,
   input  logic [DW-1:0] core_rdata,
   output logic          miso,
   output logic          miso_oe
);

   localparam int OC_W = $clog2(DW);
   localparam logic [OC_W-1:0] OUT_LAST = OC_W'(DW - 1);

   if (RD_LATENCY < 1) begin : g_bad_lat
      $error("spi_miso_shifter: RD_LATENCY must be at least 1");
   end

   logic            cap;
   logic [DW-1:0]   rd_hold;
   logic [DW-1:0]   out_sh;
   logic [OC_W-1:0] out_cnt;
   logic            data_half;

   if (RD_LATENCY == 1) begin : g_lat_one
      logic rd_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_d <= 1'b0;
         else        rd_d <= core_rd;
      end
      assign cap = rd_d;
   end else begin : g_lat_pipe
      logic [RD_LATENCY-1:0] rd_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_pipe <= '0;
         else        rd_pipe <= {rd_pipe[RD_LATENCY-2:0], core_rd};
      end
      assign cap = rd_pipe[RD_LATENCY-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hold <= '0;
      end else if (cap) begin
         rd_hold <= core_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sh    <= '0;
         out_cnt   <= '0;
         data_half <= 1'b0;
         miso      <= 1'b0;
         miso_oe   <= 1'b0;
      end else if (cs_idle) begin
         out_cnt   <= '0;
         data_half <= 1'b0;
         miso      <= 1'b0;
         miso_oe   <= 1'b0;
      end else if (load_out) begin
         out_sh    <= CHECK_WORD;
         out_cnt   <= '0;
         data_half <= 1'b0;
      end else if (sclk_fall && out_active) begin
         miso    <= out_sh[DW-1];
         miso_oe <= 1'b1;
         out_cnt <= out_cnt + 1'b1;
         if (out_cnt == OUT_LAST && !data_half) begin
            out_sh    <= rd_hold;
            data_half <= 1'b1;
            out_cnt   <= '0;
         end else begin
            out_sh <= {out_sh[DW-2:0], 1'b0};
         end
      end
   end

   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !cs_idle) |=> $stable(miso));                  // R10
   AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !miso_oe);                                        // R8
   AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> out_active);                                      // R9
   AST_OE_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(sclk_fall));                         // R3

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
   parameter int                AW          = 16,
   parameter int                DW          = 16,
   parameter logic [DW-1:0]     CHECK_WORD  = 16'hC35A,
   parameter int                RD_LATENCY  = 1,
   parameter int                SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sclk,
   input  logic          spi_cs_n,
   input  logic          spi_mosi,
   output logic          spi_miso,
   output logic          spi_miso_oe,
   output logic [AW-1:0] core_addr,
   output logic          core_rd,
   input  logic [DW-1:0] core_rdata,
   output logic          core_wr,
   output logic [DW-1:0] core_wdata
);

   logic sclk_rise;
   logic sclk_fall;
   logic cs_idle;
   logic mosi_s;
   logic load_out;
   logic out_active;

   spi_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_pin  (spi_sclk),
      .csn_pin   (spi_cs_n),
      .mosi_pin  (spi_mosi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_idle   (cs_idle),
      .mosi_s    (mosi_s)
   );

   spi_frame_ctrl #(
      .AW (AW),
      .DW (DW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .sclk_rise  (sclk_rise),
      .mosi_s     (mosi_s),
      .core_addr  (core_addr),
      .core_rd    (core_rd),
      .core_wr    (core_wr),
      .core_wdata (core_wdata),
      .load_out   (load_out),
      .out_active (out_active)
   );

   spi_miso_shifter #(
      .DW         (DW),
      .CHECK_WORD (CHECK_WORD),
      .RD_LATENCY (RD_LATENCY)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .sclk_fall  (sclk_fall),
      .load_out   (load_out),
      .out_active (out_active),
      .core_rd    (core_rd),
      .core_rdata (core_rdata),
      .miso       (spi_miso),
      .miso_oe    (spi_miso_oe)
   );

   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !(core_rd || core_wr));                           // R8
   AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |-> !spi_miso_oe);                                    // R9

endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;

   localparam int            HALF  = 8;
   localparam logic [15:0]   CHECK = 16'hC35A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso;
   logic        miso_oe;
   logic [15:0] core_addr;
   logic        core_rd;
   logic [15:0] core_rdata;
   logic        core_wr;
   logic [15:0] core_wdata;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int strobe_bad = 0;
   int stab_bad = 0;
   logic [15:0] last_rd_addr = '0;
   logic [15:0] last_wr_addr = '0;
   logic [15:0] last_wr_data = '0;
   logic        prev_rd = 1'b0;
   logic        prev_wr = 1'b0;

   logic [15:0] stub_mem [256];
   logic [15:0] shadow   [256];

   always #5 clk = ~clk;

   spi_reg_slave #(.CHECK_WORD(CHECK)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_cs_n    (cs_n),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .core_addr   (core_addr),
      .core_rd     (core_rd),
      .core_rdata  (core_rdata),
      .core_wr     (core_wr),
      .core_wdata  (core_wdata)
   );

   function automatic logic [15:0] init_word(input int i);
      logic [7:0] b = 8'(i);
      return {b ^ 8'h5A, b};
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) begin
         stub_mem[i] = init_word(i);
         shadow[i]   = init_word(i);
      end
   end

   // register file stub: one-cycle synchronous read
   always @(posedge clk) begin
      if (core_rd) core_rdata <= stub_mem[core_addr[7:0]];
      if (core_wr) stub_mem[core_addr[7:0]] <= core_wdata;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (core_rd) begin rd_cnt++; last_rd_addr = core_addr; end
         if (core_wr) begin wr_cnt++; last_wr_addr = core_addr; last_wr_data = core_wdata; end
         if ((core_rd && core_wr) || (core_rd && prev_rd) || (core_wr && prev_wr)) strobe_bad++;
         prev_rd = core_rd;
         prev_wr = core_wr;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic spi_xfer(input logic [63:0] tx, input int n,
                           output logic [63:0] rx, output logic [63:0] oe_map);
      rx = '0;
      oe_map = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         mosi = tx[n-1-i];
         repeat (HALF) @(negedge clk);
         rx     = {rx[62:0], miso};
         oe_map = {oe_map[62:0], miso_oe};
         sclk = 1'b1;
         repeat (HALF - 1) @(negedge clk);
         if (miso_oe && (miso !== rx[0])) stab_bad++;
         @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic t_reset();
      check(miso_oe === 1'b0, "R1 oe after reset", 64'(miso_oe), 0);
      check(core_rd === 1'b0, "R1 core_rd after reset", 64'(core_rd), 0);
      check(core_wr === 1'b0, "R1 core_wr after reset", 64'(core_wr), 0);
   endtask

   task automatic t_read(input logic [15:0] addr);
      logic [63:0] rx, oe_map;
      int rd0 = rd_cnt;
      int wr0 = wr_cnt;
      spi_xfer({8'h03, addr, 32'h0}, 56, rx, oe_map);
      check(rd_cnt == rd0 + 1, "R2 one read strobe", 64'(rd_cnt - rd0), 1);
      check(last_rd_addr == addr, "R2 read address", 64'(last_rd_addr), 64'(addr));
      check(wr_cnt == wr0, "R2 no write strobe in read", 64'(wr_cnt - wr0), 0);
      check(rx[31:16] == CHECK, "R3 check word", 64'(rx[31:16]), 64'(CHECK));
      check(oe_map[31:0] == 32'hFFFF_FFFF, "R3 oe during output", 64'(oe_map[31:0]),
            64'hFFFF_FFFF);
      check(rx[15:0] == shadow[addr[7:0]], "R4 read data", 64'(rx[15:0]),
            64'(shadow[addr[7:0]]));
      check(oe_map[55:32] == 24'h0, "R9 oe low in cmd/addr", 64'(oe_map[55:32]), 0);
      check(stab_bad == 0, "R10 miso steady while sclk high", 64'(stab_bad), 0);
   endtask

   task automatic t_write(input logic [15:0] addr, input logic [15:0] data);
      logic [63:0] rx, oe_map;
      int rd0 = rd_cnt;
      int wr0 = wr_cnt;
      spi_xfer({24'h0, 8'h02, addr, data}, 40, rx, oe_map);
      check(wr_cnt == wr0 + 1, "R5 one write strobe", 64'(wr_cnt - wr0), 1);
      check(last_wr_addr == addr, "R5 write address", 64'(last_wr_addr), 64'(addr));
      check(last_wr_data == data, "R5 write data", 64'(last_wr_data), 64'(data));
      check(rd_cnt == rd0, "R5 no read strobe in write", 64'(rd_cnt - rd0), 0);
      check(oe_map[39:0] == 40'h0, "R9 oe low during write", 64'(oe_map[39:0]), 0);
      shadow[addr[7:0]] = data;
   endtask

   task automatic t_short_write(input logic [15:0] addr, input logic [15:0] data);
      logic [63:0] rx, oe_map;
      int wr0 = wr_cnt;
      spi_xfer({28'h0, 8'h02, addr, data[15:4]}, 36, rx, oe_map);
      check(wr_cnt == wr0, "R6 truncated write no strobe", 64'(wr_cnt - wr0), 0);
      t_read(addr);   // R6: old value still returned
   endtask

   task automatic t_bad_cmd(input logic [7:0] cmd);
      logic [63:0] rx, oe_map;
      int rd0 = rd_cnt;
      int wr0 = wr_cnt;
      spi_xfer({24'h0, cmd, 16'h0012, 16'hFFFF}, 40, rx, oe_map);
      check((rd_cnt == rd0) && (wr_cnt == wr0), "R7 no strobe on unknown cmd",
            64'((rd_cnt - rd0) + (wr_cnt - wr0)), 0);
      check(oe_map[39:0] == 40'h0, "R7 miso stays high-z", 64'(oe_map[39:0]), 0);
   endtask

   task automatic t_abort(input logic [15:0] addr, input logic [15:0] next_addr);
      logic [63:0] rx, oe_map;
      int rd0 = rd_cnt;
      spi_xfer({32'h0, 8'h03, addr, 8'h00}, 32, rx, oe_map);
      check(rd_cnt == rd0 + 1, "R8 read strobe before abort", 64'(rd_cnt - rd0), 1);
      check(oe_map[7:0] == 8'hFF, "R8 oe driven before abort", 64'(oe_map[7:0]), 64'hFF);
      check(rx[7:0] == CHECK[15:8], "R8 partial check word", 64'(rx[7:0]),
            64'(CHECK[15:8]));
      check(miso_oe === 1'b0, "R8 oe released on chip select high", 64'(miso_oe), 0);
      t_read(next_addr);   // R8: next transaction decoded from bit 0
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements) act=150000 cycles exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_read(16'h0034);
      t_read(16'hFF81);
      t_write(16'h0034, 16'hBEEF);
      t_read(16'h0034);
      t_write(16'h00C7, 16'h8001);
      t_read(16'h00C7);
      t_short_write(16'h0010, 16'h1234);
      t_bad_cmd(8'hFF);
      t_bad_cmd(8'h01);
      t_bad_cmd(8'h83);
      t_abort(16'h0055, 16'h00AA);
      check(strobe_bad == 0, "R11 strobes single-cycle and exclusive", 64'(strobe_bad), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule